// File: doc/BRIEF.md
# Command Chain Port Register Unit

This block is the software-facing register file for a storage host adapter that works through chains of command parameter blocks (CPBs) held in memory. It serves a parameterised number of ports, two by default. Each port has its own block of four registers: a control word carrying a start bit, an event status byte, a CPB count and a pointer to the next CPB. A host writes the pointer and count, then sets the start bit. The port passes the pointer and count to a fetch engine with a one-cycle start pulse. It then follows that engine's per-CPB completion and error reports until the chain ends, an error stops it, or software stops it.

Events collect in the status byte, and reading that byte clears it. A single level-sensitive interrupt line, which other sources can share, is the OR of all ports' pending interrupts. A CPB completion raises the interrupt only when that CPB's header carries its interrupt-enable flag. The fetch engine passes this flag, which is header bit 19, on the `fetchIntEn` pin together with its completion strobe. Errors always raise the interrupt.

Top module: `cmd_chain_regs`

## Requirements
- R1: After reset every register reads 0, `irq` is 0 and no `fetchStart` bit is set.
- R2: Port p's block starts at byte address 0x80 + 0x20*p. Within a block, the control word is at 0x0, status at 0x2, count at 0x4 (16 bits, so upper write bits are dropped) and next-CPB pointer at 0xC (32 bits). Count and pointer read back what was written. Reads of any address outside the blocks return 0.
- R3: Writing the control word with bit 7 set, while the port is idle and its count is nonzero, makes the port busy. In the following cycle `fetchStart[p]` pulses for exactly one cycle, with `fetchAddr`/`fetchCount` equal to the pointer and count. While the port is busy, the control word reads 0x0080.
- R4: Each completion reported while the port is busy decrements the count. The completion that brings the count to 0 sets status bit 7 (done) and returns the port to idle, so the control word then reads 0.
- R5: A completion raises `irq` only if its `fetchIntEn` (header bit 19) is 1. A completion with the flag at 0 leaves `irq` low.
- R6: A status read returns all pending flags and clears them, along with the port's interrupt, from the next cycle on. Status bit 2 is reserved and always reads 0.
- R7: A CPB error report sets status bit 1, and a bus error report sets status bit 0. Either one returns the port to idle without decrementing the count and always raises `irq`. An error takes precedence over a completion reported in the same cycle.
- R8: While the port is busy, further start writes produce no new `fetchStart`, and writes to the count or pointer are ignored.
- R9: Writing the control word with bit 7 clear stops a busy port. Fetch reports that arrive while the port is idle change nothing.
- R10: A start write while the count is 0 produces no `fetchStart` and no interrupt. It sets done immediately.
- R11: An event that lands in the same cycle as a status read is not lost. The read returns the old flags, and the new flag and interrupt remain pending.
- R12: Ports operate independently, and `irq` is the OR of every port's pending interrupt.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| regAddr | input | ADDR_W | Register byte address |
| regWe | input | 1 | Write strobe |
| regRe | input | 1 | Read strobe (status reads clear) |
| regWdata | input | DATA_W | Write data |
| regRdata | output | DATA_W | Read data, combinational from address |
| irq | output | 1 | Level interrupt, OR of all ports |
| fetchStart | output | N_PORTS | One-cycle start pulse per port |
| fetchAddr | output | N_PORTS*PTR_W | Next-CPB pointer per port |
| fetchCount | output | N_PORTS*CNT_W | CPB count per port |
| fetchDone | input | N_PORTS | One CPB completed |
| fetchIntEn | input | N_PORTS | Header bit 19 of the completed CPB |
| fetchCpbErr | input | N_PORTS | CPB error report |
| fetchBusErr | input | N_PORTS | Bus error report |

## Verification
The key overlap is a status read that clears a port's flags in the same cycle as a fetch report that sets one. If clear were given priority, the new event would be lost. The bench raises a completion with its interrupt flag on the same clock edge on which it reads status. The value returned must be the flags from before the event. After that edge, `irq` must still be high, and a second read must show the done bit.

// File: rtl/ccr_pkg.sv
package ccr_pkg;
  localparam int OFS_W = 5;
  localparam logic [OFS_W-1:0] OFS_CTL  = 5'h00;
  localparam logic [OFS_W-1:0] OFS_STAT = 5'h02;
  localparam logic [OFS_W-1:0] OFS_CNT  = 5'h04;
  localparam logic [OFS_W-1:0] OFS_NXT  = 5'h0C;
  localparam int GO_BIT = 7;
  localparam int ST_BUS = 0;
  localparam int ST_CPB = 1;
  localparam int ST_DONE = 7;

  typedef struct packed {
    logic go;
    logic ldCnt;
    logic ldNxt;
    logic decCnt;
    logic setDone;
    logic setCpbErr;
    logic setBusErr;
    logic setIrq;
    logic clrStat;
  } portStrobe_t;
endpackage

// File: rtl/ccr_port_ctrl.sv
module ccr_port_ctrl
  import ccr_pkg::*;
(
  input  logic             clk,
  input  logic             rst,
  input  logic             sel,
  input  logic [OFS_W-1:0] ofs,
  input  logic             we,
  input  logic             re,
  input  logic             wGo,
  input  logic             fetchDone,
  input  logic             fetchIntEn,
  input  logic             fetchCpbErr,
  input  logic             fetchBusErr,
  input  logic             cntZero,
  input  logic             cntOne,
  output portStrobe_t      strb,
  output logic             busy
);
  logic busyQ;
  logic wrCtl;
  logic stopReq;
  logic anyErr;

  assign busy = busyQ;
  assign wrCtl = sel && we && (ofs == OFS_CTL);
  assign stopReq = wrCtl && !wGo && busyQ;
  assign anyErr = fetchCpbErr || fetchBusErr;

  always_comb begin
    strb = '0;
    if (wrCtl && wGo && !busyQ) begin
      if (cntZero) strb.setDone = 1'b1;
      else strb.go = 1'b1;
    end
    strb.ldCnt = sel && we && (ofs == OFS_CNT) && !busyQ;
    strb.ldNxt = sel && we && (ofs == OFS_NXT) && !busyQ;
    strb.clrStat = sel && re && (ofs == OFS_STAT);
    if (busyQ && !stopReq) begin
      if (anyErr) begin
        strb.setCpbErr = fetchCpbErr;
        strb.setBusErr = fetchBusErr;
        strb.setIrq = 1'b1;
      end else if (fetchDone) begin
        strb.decCnt = 1'b1;
        strb.setIrq = fetchIntEn;
        if (cntOne) strb.setDone = 1'b1;
      end
    end
  end

  always_ff @(posedge clk) begin
    if (rst) busyQ <= 1'b0;
    else if (strb.go) busyQ <= 1'b1;
    else if (stopReq || strb.setCpbErr || strb.setBusErr || (strb.decCnt && cntOne))
      busyQ <= 1'b0;
  end
endmodule

// File: rtl/ccr_port_dpath.sv
module ccr_port_dpath
  import ccr_pkg::*;
#(
  parameter int DATA_W = 32,
  parameter int CNT_W = 16,
  parameter int PTR_W = 32
) (
  input  logic              clk,
  input  logic              rst,
  input  portStrobe_t       strb,
  input  logic              busy,
  input  logic [OFS_W-1:0]  ofs,
  input  logic [DATA_W-1:0] wdata,
  output logic              cntZero,
  output logic              cntOne,
  output logic [DATA_W-1:0] rdData,
  output logic              irqPend,
  output logic              startPulse,
  output logic [PTR_W-1:0]  nxtPtr,
  output logic [CNT_W-1:0]  cntVal
);
  logic [CNT_W-1:0] cntQ;
  logic [PTR_W-1:0] nxtQ;
  logic [7:0]       statQ;
  logic [7:0]       statSet;
  logic             irqQ;
  logic             startQ;

  assign cntZero = (cntQ == '0);
  assign cntOne = (cntQ == CNT_W'(1));
  assign irqPend = irqQ;
  assign startPulse = startQ;
  assign nxtPtr = nxtQ;
  assign cntVal = cntQ;

  always_comb begin
    statSet = '0;
    statSet[ST_DONE] = strb.setDone;
    statSet[ST_CPB] = strb.setCpbErr;
    statSet[ST_BUS] = strb.setBusErr;
  end

  always_ff @(posedge clk) begin
    if (rst) begin
      cntQ <= '0;
      nxtQ <= '0;
      statQ <= '0;
      irqQ <= 1'b0;
      startQ <= 1'b0;
    end else begin
      startQ <= strb.go;
      statQ <= (strb.clrStat ? 8'h00 : statQ) | statSet;
      irqQ <= (irqQ && !strb.clrStat) || strb.setIrq;
      if (strb.ldCnt) cntQ <= wdata[CNT_W-1:0];
      else if (strb.decCnt) cntQ <= cntQ - CNT_W'(1);
      if (strb.ldNxt) nxtQ <= wdata[PTR_W-1:0];
    end
  end

  always_comb begin
    rdData = '0;
    case (ofs)
      OFS_CTL:  rdData[GO_BIT] = busy;
      OFS_STAT: rdData[7:0] = statQ;
      OFS_CNT:  rdData[CNT_W-1:0] = cntQ;
      OFS_NXT:  rdData[PTR_W-1:0] = nxtQ;
      default:  rdData = '0;
    endcase
  end
endmodule

// File: rtl/cmd_chain_regs.sv
module cmd_chain_regs
  import ccr_pkg::*;
#(
  parameter int N_PORTS = 2,
  parameter int ADDR_W = 8,
  parameter int DATA_W = 32,
  parameter int CNT_W = 16,
  parameter int PTR_W = 32,
  parameter int BLK_BASE = 'h80
) (
  input  logic                     clk,
  input  logic                     rst,
  input  logic [ADDR_W-1:0]        regAddr,
  input  logic                     regWe,
  input  logic                     regRe,
  input  logic [DATA_W-1:0]        regWdata,
  output logic [DATA_W-1:0]        regRdata,
  output logic                     irq,
  output logic [N_PORTS-1:0]       fetchStart,
  output logic [N_PORTS*PTR_W-1:0] fetchAddr,
  output logic [N_PORTS*CNT_W-1:0] fetchCount,
  input  logic [N_PORTS-1:0]       fetchDone,
  input  logic [N_PORTS-1:0]       fetchIntEn,
  input  logic [N_PORTS-1:0]       fetchCpbErr,
  input  logic [N_PORTS-1:0]       fetchBusErr
);
  localparam int BLK_STRIDE = 1 << OFS_W;

  logic [N_PORTS-1:0] hit;
  logic [N_PORTS-1:0] portIrq;
  logic [DATA_W-1:0]  portRd [N_PORTS];
  logic [OFS_W-1:0]   ofs;

  assign ofs = regAddr[OFS_W-1:0];

  for (genvar p = 0; p < N_PORTS; p++) begin : g_port
    localparam int BLK_ADDR = BLK_BASE + p * BLK_STRIDE;
    portStrobe_t strb;
    logic busy, cntZero, cntOne;

    assign hit[p] = (regAddr[ADDR_W-1:OFS_W] == BLK_ADDR[ADDR_W-1:OFS_W]);

    ccr_port_ctrl u_ctrl (
      .clk(clk), .rst(rst), .sel(hit[p]), .ofs(ofs), .we(regWe), .re(regRe),
      .wGo(regWdata[GO_BIT]), .fetchDone(fetchDone[p]), .fetchIntEn(fetchIntEn[p]),
      .fetchCpbErr(fetchCpbErr[p]), .fetchBusErr(fetchBusErr[p]),
      .cntZero(cntZero), .cntOne(cntOne), .strb(strb), .busy(busy)
    );

    ccr_port_dpath #(.DATA_W(DATA_W), .CNT_W(CNT_W), .PTR_W(PTR_W)) u_dpath (
      .clk(clk), .rst(rst), .strb(strb), .busy(busy), .ofs(ofs), .wdata(regWdata),
      .cntZero(cntZero), .cntOne(cntOne), .rdData(portRd[p]), .irqPend(portIrq[p]),
      .startPulse(fetchStart[p]), .nxtPtr(fetchAddr[p*PTR_W +: PTR_W]),
      .cntVal(fetchCount[p*CNT_W +: CNT_W])
    );
  end

  always_comb begin
    regRdata = '0;
    for (int p = 0; p < N_PORTS; p++)
      if (hit[p]) regRdata = portRd[p];
  end

  assign irq = |portIrq;
endmodule

// File: rtl/cmd_chain_regs_checker.sv
module cmd_chain_regs_checker #(
  parameter int N_PORTS = 2,
  parameter int ADDR_W = 8,
  parameter int DATA_W = 32,
  parameter int BLK_BASE = 'h80
) (
  input logic               clk,
  input logic               rst,
  input logic [ADDR_W-1:0]  regAddr,
  input logic               regWe,
  input logic               regRe,
  input logic               goBit,
  input logic [DATA_W-1:0]  regRdata,
  input logic               irq,
  input logic [N_PORTS-1:0] fetchStart,
  input logic [N_PORTS-1:0] fetchDone,
  input logic [N_PORTS-1:0] fetchCpbErr,
  input logic [N_PORTS-1:0] fetchBusErr
);
  localparam int SPAN = N_PORTS * 32;
  logic inBlocks, isStat;

  assign inBlocks = (int'(regAddr) >= BLK_BASE) && (int'(regAddr) < BLK_BASE + SPAN);
  assign isStat = inBlocks && (regAddr[4:0] == 5'h02);

  // R2: addresses outside every port block read as zero
  p_unmapped_zero_r2: assert property (@(posedge clk) disable iff (rst)
    (regRe && !inBlocks) |-> (regRdata == '0));

  // R6: reserved status bit and upper bits are never set
  p_rsvd_zero_r6: assert property (@(posedge clk) disable iff (rst)
    (regRe && isStat) |-> (regRdata[2] == 1'b0 && regRdata[DATA_W-1:8] == '0));

  // R5/R7: interrupt only rises after a fetch report
  p_irq_cause_r5: assert property (@(posedge clk) disable iff (rst)
    $rose(irq) |-> $past(|(fetchDone | fetchCpbErr | fetchBusErr)));

  for (genvar p = 0; p < N_PORTS; p++) begin : g_chk
    // R3: start is a single-cycle pulse
    p_start_single_r3: assert property (@(posedge clk) disable iff (rst)
      fetchStart[p] |=> !fetchStart[p]);
    // R3: start follows a write with the start bit
    p_start_cause_r3: assert property (@(posedge clk) disable iff (rst)
      $rose(fetchStart[p]) |-> $past(regWe && goBit));
  end
endmodule

bind cmd_chain_regs cmd_chain_regs_checker #(
  .N_PORTS(N_PORTS), .ADDR_W(ADDR_W), .DATA_W(DATA_W), .BLK_BASE(BLK_BASE)
) u_chk (
  .clk(clk), .rst(rst), .regAddr(regAddr), .regWe(regWe), .regRe(regRe),
  .goBit(regWdata[7]), .regRdata(regRdata), .irq(irq), .fetchStart(fetchStart),
  .fetchDone(fetchDone), .fetchCpbErr(fetchCpbErr), .fetchBusErr(fetchBusErr)
);

// File: tb/tb_cmd_chain_regs.sv
module tb_cmd_chain_regs;
  logic clk = 0;
  logic rst = 1;
  logic [7:0]  regAddr = '0;
  logic        regWe = 0, regRe = 0;
  logic [31:0] regWdata = '0;
  logic [31:0] regRdata;
  logic        irq;
  logic [1:0]  fetchStart;
  logic [63:0] fetchAddr;
  logic [31:0] fetchCount;
  logic [1:0]  fetchDone = '0, fetchIntEn = '0, fetchCpbErr = '0, fetchBusErr = '0;
  int checks = 0, errors = 0;
  logic [31:0] v;

  always #4 clk = ~clk;

  cmd_chain_regs dut (.*);

  task automatic chk(string tag, logic [31:0] got, logic [31:0] exp);
    checks++;
    if (got !== exp) begin
      errors++;
      $display("FAIL %s: got %h expected %h", tag, got, exp);
    end
  endtask

  task automatic wr(logic [7:0] a, logic [31:0] d);
    @(negedge clk); regAddr = a; regWdata = d; regWe = 1;
    @(negedge clk); regWe = 0;
  endtask

  task automatic rd(logic [7:0] a, output logic [31:0] d);
    @(negedge clk); regAddr = a; regRe = 1; #1 d = regRdata;
    @(negedge clk); regRe = 0;
  endtask

  task automatic resp(int p, bit d, bit ie, bit ce, bit be);
    @(negedge clk);
    fetchDone[p] = d; fetchIntEn[p] = ie; fetchCpbErr[p] = ce; fetchBusErr[p] = be;
    @(negedge clk);
    fetchDone = '0; fetchIntEn = '0; fetchCpbErr = '0; fetchBusErr = '0;
  endtask

  // {isWrite, addr, data/expected}
  localparam logic [40:0] VEC [11] = '{
    {1'b1, 8'h84, 32'h0000_0003},
    {1'b1, 8'h8C, 32'h1000_0040},
    {1'b1, 8'hA4, 32'h0001_0005},
    {1'b1, 8'hAC, 32'h2000_0080},
    {1'b0, 8'h84, 32'h0000_0003},
    {1'b0, 8'h8C, 32'h1000_0040},
    {1'b0, 8'hA4, 32'h0000_0005},
    {1'b0, 8'hAC, 32'h2000_0080},
    {1'b0, 8'h80, 32'h0000_0000},
    {1'b0, 8'h82, 32'h0000_0000},
    {1'b0, 8'h40, 32'h0000_0000}
  };

  initial begin
    repeat (100000) @(posedge clk);
    errors++; checks++;
    $display("FAIL watchdog: got timeout expected completion");
    $display("Simulation finished: %0d checks, %0d errors", checks, errors);
    $finish;
  end

  initial begin
    repeat (3) @(negedge clk);
    rst = 0;
    // R1 reset state
    chk("R1 irq", {31'b0, irq}, 0);
    chk("R1 fetchStart", {30'b0, fetchStart}, 0);
    rd(8'hA4, v); chk("R1 count", v, 0);

    // R2 table: map, widths, unmapped
    for (int i = 0; i < 11; i++) begin
      if (VEC[i][40]) wr(VEC[i][39:32], VEC[i][31:0]);
      else begin
        rd(VEC[i][39:32], v);
        chk($sformatf("R2 vec%0d", i), v, VEC[i][31:0]);
      end
    end

    // R3 start
    wr(8'h80, 32'h80);
    chk("R3 start pulse", {30'b0, fetchStart}, 2'b01);
    chk("R3 fetchAddr", fetchAddr[31:0], 32'h1000_0040);
    chk("R3 fetchCount", {16'b0, fetchCount[15:0]}, 3);
    @(negedge clk); chk("R3 pulse one cycle", {30'b0, fetchStart}, 0);
    rd(8'h80, v); chk("R3 busy ctl", v, 32'h80);

    // R8 busy writes ignored
    wr(8'h80, 32'h80); chk("R8 no restart", {30'b0, fetchStart}, 0);
    wr(8'h84, 32'h9); rd(8'h84, v); chk("R8 count locked", v, 3);
    wr(8'h8C, 32'h5); rd(8'h8C, v); chk("R8 ptr locked", v, 32'h1000_0040);

    // R4/R5 completions
    resp(0, 1, 0, 0, 0);
    rd(8'h84, v); chk("R4 decrement", v, 2);
    chk("R5 no irq without enable", {31'b0, irq}, 0);
    resp(0, 1, 1, 0, 0);
    chk("R5 irq with enable", {31'b0, irq}, 1);
    rd(8'h82, v); chk("R6 status before done", v, 0);
    chk("R6 irq cleared by read", {31'b0, irq}, 0);
    resp(0, 1, 0, 0, 0);
    rd(8'h80, v); chk("R4 idle after last", v, 0);
    chk("R5 last without enable", {31'b0, irq}, 0);
    rd(8'h82, v); chk("R4 done flag (R6 bit2 zero)", v, 32'h80);
    rd(8'h82, v); chk("R6 read clears", v, 0);

    // R7 errors on port 1
    wr(8'hA0, 32'h80); chk("R7 p1 start", {30'b0, fetchStart}, 2'b10);
    resp(1, 1, 0, 1, 0);
    chk("R7 irq on cpb error", {31'b0, irq}, 1);
    rd(8'hA0, v); chk("R7 idle after error", v, 0);
    rd(8'hA4, v); chk("R7 no decrement", v, 5);
    rd(8'hA2, v); chk("R7 cpb error bit", v, 32'h02);
    wr(8'hA0, 32'h80);
    resp(1, 0, 0, 0, 1);
    rd(8'hA2, v); chk("R7 bus error bit", v, 32'h01);
    chk("R7 irq cleared", {31'b0, irq}, 0);

    // R9 stop
    wr(8'hA0, 32'h80);
    wr(8'hA0, 32'h0);
    rd(8'hA0, v); chk("R9 stopped", v, 0);
    resp(1, 1, 1, 0, 0);
    chk("R9 report ignored irq", {31'b0, irq}, 0);
    rd(8'hA4, v); chk("R9 count kept", v, 5);
    rd(8'hA2, v); chk("R9 status clean", v, 0);

    // R10 zero count
    wr(8'h84, 32'h0);
    wr(8'h80, 32'h80);
    chk("R10 no start", {30'b0, fetchStart}, 0);
    chk("R10 no irq", {31'b0, irq}, 0);
    rd(8'h80, v); chk("R10 idle", v, 0);
    rd(8'h82, v); chk("R10 done set", v, 32'h80);

    // R11 read and event in the same cycle
    wr(8'h84, 32'h1);
    wr(8'h80, 32'h80);
    @(negedge clk);
    regAddr = 8'h82; regRe = 1; fetchDone[0] = 1; fetchIntEn[0] = 1;
    #1 v = regRdata;
    @(negedge clk);
    regRe = 0; fetchDone = '0; fetchIntEn = '0;
    chk("R11 old flags returned", v, 0);
    chk("R11 irq kept", {31'b0, irq}, 1);
    rd(8'h82, v); chk("R11 done kept", v, 32'h80);

    // R12 independent ports, shared irq
    wr(8'h84, 32'h2);
    wr(8'h80, 32'h80);
    wr(8'hA0, 32'h80);
    resp(1, 1, 1, 0, 0);
    chk("R12 irq from port1", {31'b0, irq}, 1);
    rd(8'h84, v); chk("R12 port0 untouched", v, 2);
    rd(8'hA4, v); chk("R12 port1 decrement", v, 4);
    rd(8'h82, v); chk("R12 port0 status", v, 0);
    chk("R12 irq held by port1", {31'b0, irq}, 1);
    rd(8'hA2, v); chk("R12 port1 status", v, 0);
    chk("R12 irq released", {31'b0, irq}, 0);
    wr(8'h80, 32'h0);
    wr(8'hA0, 32'h0);

    $display("Simulation finished: %0d checks, %0d errors", checks, errors);
    $finish;
  end
endmodule